// File: doc/BRIEF.md
# Random-Jump Sequential Pattern Generator

This block produces a stream of 32-bit test words for exercising a downstream analyser. Most of the time the word simply counts upward by one per generator step. At irregular, pseudo-random moments the word jumps to a pseudo-random value, and a marker output flags each jump. A checker downstream can count the jumps it detects and compare that count against the markers.

A 32-bit right-shifting linear feedback register is the single source of randomness. At each jump its current value becomes the new data word, and five of its upper bits set how many steps the following sequential run lasts. The generator runs off the system clock, gated by a one-cycle step strobe from an external divider (one pulse in twelve clocks in the intended system). A run input freezes the whole block when low.

Top module: `rjump_pattern_gen`

## Requirements
- R1: After reset, `data_o` is 0 and `event_o` is 0; the shift register holds the nonzero seed 0xACE15EED and the run counter is 0.
- R2: On every step (`tick_i` and `run_i` both high), the shift register L becomes (L >> 1) XOR (L[0] ? 0x80200003 : 0), a maximal-length 32-bit polynomial, so it never reaches zero.
- R3: On a step where the run counter is nonzero, `data_o` increases by one (modulo 2^32) and the counter decreases by one.
- R4: On a step where the run counter is zero (a jump), `data_o` takes the shift register value as it was before that step.
- R5: At a jump, the counter is reloaded from field F = L[31:27] (L before the step) as F-1, or 0 when F is 0; the number of steps from one jump to the next is therefore F, or 1 when F is 0. The first step after reset is a jump.
- R6: `event_o` rises on the clock edge of a jump step and stays high until the next step, so it marks each jump for exactly one generator step; it is low after any step that is not a jump.
- R7: While `run_i` is high and `tick_i` is low, neither `data_o`, `event_o` nor internal state changes.
- R8: While `run_i` is low, the shift register, counter and `data_o` hold, and `event_o` is driven low from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Step strobe from the rate divider, one clock wide |
| run_i | input | 1 | Run enable; low freezes the generator |
| data_o | output | 32 | Generated data word |
| event_o | output | 1 | Jump marker, high for one generator step after each jump |

## Verification
The bench aims at the very first step after reset, which must be a jump to the seed; a design that started with a full counter would increment from zero instead. It runs long enough for the five-bit field to hit zero and one, where back-to-back jumps occur; a design that loaded zero literally would stall or wrap the counter to 31 and produce a run of the wrong length. It interleaves strobe-low and run-low cycles, where a design that let the marker linger, or advanced the register without a strobe, would drift from the reference model by the next compared word.

// File: rtl/rjpg_pkg.sv
`timescale 1ns/1ps
package rjpg_pkg;

    // default geometry
    localparam int unsigned WORD_W_DEF  = 32;
    localparam int unsigned RUN_W_DEF   = 5;
    localparam logic [31:0] POLY_DEF    = 32'h8020_0003;
    localparam logic [31:0] SEED_DEF    = 32'hACE1_5EED;

    // control bundle shared between the generator stages
    typedef struct packed {
        logic step;   // generator advances this clock
        logic jump;   // run counter expired on this step
    } gen_ctrl_t;

endpackage

// File: rtl/rjpg_lfsr.sv
`timescale 1ns/1ps
module rjpg_lfsr #(
    parameter int unsigned         W    = 32,
    parameter logic [W-1:0]        POLY = '1,
    parameter logic [W-1:0]        SEED = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         adv_i,
    output logic [W-1:0] state_o
);

    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_state_t;

    lfsr_state_t st_d, st_q;
    logic [W-1:0] fb_mask;

    // feedback mask: tap bits gated by the bit shifted out
    for (genvar b = 0; b < W; b++) begin : g_tap
        assign fb_mask[b] = POLY[b] & st_q.sr[0];
    end

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.sr = (st_q.sr >> 1) ^ fb_mask;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q.sr;

endmodule

// File: rtl/rjpg_run_timer.sv
`timescale 1ns/1ps
module rjpg_run_timer #(
    parameter int unsigned W = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         adv_i,
    input  logic [W-1:0] reload_i,
    output logic         jump_o,
    output logic [W-1:0] count_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } timer_state_t;

    localparam logic [W-1:0] ONE = W'(1);

    timer_state_t st_d, st_q;
    logic         expired;

    always_comb begin
        st_d    = st_q;
        expired = (st_q.cnt == '0);
        if (adv_i) begin
            if (expired) begin
                // a zero reload behaves as a one-step run
                st_d.cnt = (reload_i == '0) ? '0 : (reload_i - ONE);
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign jump_o  = adv_i & expired;
    assign count_o = st_q.cnt;

endmodule

// File: rtl/rjpg_word_counter.sv
`timescale 1ns/1ps
module rjpg_word_counter
    import rjpg_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         run_i,
    input  gen_ctrl_t    ctrl_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] data_o,
    output logic         event_o
);

    typedef struct packed {
        logic [W-1:0] word;
        logic         mark;
    } word_state_t;

    word_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_i.step) begin
            st_d.word = ctrl_i.jump ? load_val_i : (st_q.word + W'(1));
        end
        // marker follows jumps per step, is cleared while halted
        if (!run_i) begin
            st_d.mark = 1'b0;
        end else if (tick_i) begin
            st_d.mark = ctrl_i.jump;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.word <= '0;
            st_q.mark <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.word;
    assign event_o = st_q.mark;

endmodule

// File: rtl/rjump_pattern_gen.sv
`timescale 1ns/1ps
module rjump_pattern_gen
    import rjpg_pkg::*;
#(
    parameter int unsigned         WORD_W = WORD_W_DEF,
    parameter int unsigned         RUN_W  = RUN_W_DEF,
    parameter logic [WORD_W-1:0]   POLY   = POLY_DEF,
    parameter logic [WORD_W-1:0]   SEED   = SEED_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              run_i,
    output logic [WORD_W-1:0] data_o,
    output logic              event_o
);

    localparam int unsigned RUN_LSB = WORD_W - RUN_W;

    gen_ctrl_t         ctrl;
    logic [WORD_W-1:0] lfsr_val;
    logic [RUN_W-1:0]  run_cnt;
    logic              jump;

    assign ctrl.step = tick_i & run_i;
    assign ctrl.jump = jump;

    rjpg_lfsr #(
        .W    (WORD_W),
        .POLY (POLY),
        .SEED (SEED)
    ) i_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .adv_i   (ctrl.step),
        .state_o (lfsr_val)
    );

    rjpg_run_timer #(
        .W (RUN_W)
    ) i_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .adv_i    (ctrl.step),
        .reload_i (lfsr_val[RUN_LSB +: RUN_W]),
        .jump_o   (jump),
        .count_o  (run_cnt)
    );

    rjpg_word_counter #(
        .W (WORD_W)
    ) i_word (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .run_i      (run_i),
        .ctrl_i     (ctrl),
        .load_val_i (lfsr_val),
        .data_o     (data_o),
        .event_o    (event_o)
    );

endmodule

// File: rtl/rjpg_checker.sv
`timescale 1ns/1ps
module rjpg_checker #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned RUN_W  = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              run_i,
    input logic [WORD_W-1:0] data_o,
    input logic              event_o,
    input logic [WORD_W-1:0] lfsr_i,
    input logic [RUN_W-1:0]  cnt_i,
    input logic              jump_i
);

    AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_i != '0); // R2

    AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && run_i && cnt_i != '0) |=> data_o == $past(data_o) + WORD_W'(1)); // R3

    AST_JUMP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && run_i && cnt_i == '0) |=> data_o == $past(lfsr_i)); // R4

    AST_RUN_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && run_i && cnt_i != '0) |=> cnt_i == $past(cnt_i) - RUN_W'(1)); // R5

    AST_EVENT_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && run_i) |=> event_o == $past(jump_i)); // R6

    AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && run_i) |=> $stable(data_o) && $stable(event_o) && $stable(lfsr_i)); // R7

    AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i) |=> !event_o && $stable(data_o) && $stable(cnt_i)); // R8

endmodule

bind rjump_pattern_gen rjpg_checker #(
    .WORD_W (WORD_W),
    .RUN_W  (RUN_W)
) i_rjpg_checker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .run_i   (run_i),
    .data_o  (data_o),
    .event_o (event_o),
    .lfsr_i  (lfsr_val),
    .cnt_i   (run_cnt),
    .jump_i  (jump)
);

// File: tb/test_rjump_pattern_gen.sv
`timescale 1ns/1ps
module test_rjump_pattern_gen;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        tick_i = 1'b0;
    logic        run_i = 1'b0;
    logic [31:0] data_o;
    logic        event_o;

    always #2.5 clk_i = ~clk_i;

    rjump_pattern_gen i_rjump_pattern_gen (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .run_i   (run_i),
        .data_o  (data_o),
        .event_o (event_o)
    );

    typedef struct {
        logic [31:0] data;
        logic        evt;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   n_jumps  = 0;
    int   n_zero_f = 0;
    bit   finished = 1'b0;

    // reference model
    logic [31:0] m_lfsr = 32'hACE1_5EED;
    logic [4:0]  m_cnt  = '0;
    logic [31:0] m_data = '0;
    logic        m_evt  = 1'b0;

    task automatic drive_cycle(input logic tk, input logic rn, input string force_tag = "");
        exp_t  it;
        string tg;
        logic  jmp;
        logic [4:0] fld;
        @(negedge clk_i);
        tick_i = tk;
        run_i  = rn;
        jmp = 1'b0;
        if (!rn) begin
            m_evt = 1'b0;
            tg = "R8";
        end else if (!tk) begin
            tg = "R7";
        end else begin
            jmp = (m_cnt == 5'd0);
            fld = m_lfsr[31:27];
            if (jmp) begin
                m_data = m_lfsr;
                m_cnt  = (fld == 5'd0) ? 5'd0 : fld - 5'd1;
                n_jumps++;
                if (fld == 5'd0) n_zero_f++;
                tg = "R2,R4,R5,R6";
            end else begin
                m_data = m_data + 32'd1;
                m_cnt  = m_cnt - 5'd1;
                tg = "R3,R5,R6";
            end
            m_evt  = jmp;
            m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 32'h8020_0003 : 32'h0);
        end
        it.data = m_data;
        it.evt  = m_evt;
        it.tag  = (force_tag != "") ? force_tag : tg;
        q.push_back(it);
    endtask

    // monitor: compare after each rising edge
    always begin
        exp_t it;
        @(posedge clk_i);
        #1;
        if (q.size() > 0) begin
            it = q.pop_front();
            n_checks++;
            if (data_o !== it.data || event_o !== it.evt) begin
                n_fail++;
                $display("FAIL %s: data=%08h event=%0b expected data=%08h event=%0b",
                         it.tag, data_o, event_o, it.data, it.evt);
            end
        end
    end

    task automatic check_flag(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        // R1: reset state seen with no step
        drive_cycle(1'b0, 1'b1, "R1");
        // first step must jump to the seed (R5, R4)
        drive_cycle(1'b1, 1'b1);
        // full-rate stepping
        for (int i = 0; i < 1500; i++) drive_cycle(1'b1, 1'b1);
        // divided rate, one step in twelve clocks
        for (int i = 0; i < 1200; i++) drive_cycle((i % 12) == 11, 1'b1);
        // mixed strobe and run patterns
        for (int i = 0; i < 2000; i++) begin
            int r = int'($urandom_range(0, 7));
            drive_cycle(r < 4, r != 7);
        end
        // halt with a pending marker: R8
        for (int i = 0; i < 40; i++) drive_cycle(1'b1, 1'b1);
        drive_cycle(1'b1, 1'b0);
        drive_cycle(1'b0, 1'b0);
        drive_cycle(1'b1, 1'b1);
        repeat (3) @(negedge clk_i);
        // R5: zero-field reloads must have been reached by the run
        check_flag(n_zero_f > 0, "R5", n_zero_f, 1);
        check_flag(n_jumps > 100, "R6", n_jumps, 101);
        finished = 1'b1;
    end

    initial begin
        fork
            begin
                wait (finished);
            end
            begin
                repeat (200000) @(posedge clk_i);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule